// File: doc/BRIEF.md
# Grouped Vector Integer-to-Float Converter

The block turns signed 32-bit integers into IEEE-754 single-precision values for a whole group of vector registers in one operation. A group is two or four consecutive, aligned registers. Each register holds `VL/32` lanes. Every lane of every source register is converted, with no predication. The result goes to the same lane of the matching register in an aligned destination group.

The block owns no storage of its own beyond a small result buffer. It drives the read address of a register file and converts a whole register per cycle, all lanes in parallel, into that buffer. Only after every source has been read does it write the buffer back, one register per cycle, through the register file's write port. Overlapping or identical source and destination groups are therefore handled correctly.

The rounding mode comes from a control input and is sampled when the operation starts. A sticky inexact flag reports whether any lane lost precision.

Top module: `vcvt_group`

## Requirements
- R1: A lane holding an integer whose magnitude fits in 24 bits converts exactly; for example 1 gives 0x3F800000 and -1 gives 0xBF800000. Bits [32k+31:32k] of a destination register hold the result for bits [32k+31:32k] of the matching source register.
- R2: An input of 0 gives +0.0 (0x00000000). An input of 0x80000000 (-2^31) gives exactly 0xCF000000.
- R3: Magnitudes that need more than 24 significant bits are rounded by the `rmode` value captured at start. The encodings are 00 nearest with ties to even, 01 toward +infinity, 10 toward -infinity, and 11 toward zero. For example, 16777217 gives 0x4B800000 under 00, 10 and 11, and gives 0x4B800001 under 01.
- R4: A rounding carry out of the mantissa raises the exponent. 0x7FFFFFFF gives 0x4F000000 under mode 00 and 0x4EFFFFFF under mode 11.
- R5: `inexact` clears when an operation is accepted. It is set if any converted lane dropped nonzero bits. It holds its value while the block is idle.
- R6: With `mode4`=0 the source registers are 2*`src_grp` and 2*`src_grp`+1. With `mode4`=1 they are 4*`src_grp[2:0]` through 4*`src_grp[2:0]`+3, and `src_grp[3]` is ignored. `dst_grp` maps onto the destination registers in the same way. Registers are read and written in ascending order.
- R7: Every source register of the group is read before any destination register is written. The results always reflect the source contents as they were when the operation started, including when the source and destination groups are the same.
- R8: A `start` pulse that is sampled while idle makes `busy` high from the next cycle. N read cycles follow, where N is the group size, and then N cycles with `rf_we` high. In the next cycle `done` is high for exactly one cycle and `busy` is low.
- R9: A `start` that arrives while `busy` is high is ignored. No writes happen other than the N writes of the accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode4 | input | 1 | 0: two-register group, 1: four-register group |
| src_grp | input | 4 | Source group field |
| dst_grp | input | 4 | Destination group field |
| rmode | input | 2 | Rounding mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| inexact | output | 1 | Sticky inexact flag of the last operation |
| rf_raddr | output | 5 | Register file read address |
| rf_rdata | input | VL | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write address |
| rf_wdata | output | VL | Register file write data |

## Verification
A wrong lane count shows up immediately as bad data in the first write of a result. A wrong group base or an off-by-one in the step counter shows up as a misplaced write address as soon as `rf_we` rises. A sequencer that writes early appears as a mismatch in the in-place group, because the later reads then see converted data. A stale inexact flag or a missed capture of the rounding mode becomes visible at `done`, or in the next operation's lane values, within one operation.

// File: rtl/vcvt_pkg.sv
package vcvt_pkg;

    localparam int LANE_W   = 32;
    localparam int EXP_TOP  = 158;   // bias 127 + 31

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_UP      = 2'b01,
        RM_DOWN    = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } state_e;

    typedef struct packed {
        logic        sign;
        logic [7:0]  exp;
        logic [22:0] frac;
    } sp_t;

    function automatic logic round_up(rmode_e rm, logic sign, logic lsb,
                                      logic guard, logic sticky);
        logic lost;
        lost = guard | sticky;
        case (rm)
            RM_NEAREST: round_up = guard & (sticky | lsb);
            RM_UP:      round_up = ~sign & lost;
            RM_DOWN:    round_up = sign & lost;
            default:    round_up = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lzc.sv
module lzc #(
    parameter int W  = 32,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  v,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (v[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/int2fp_lane.sv
module int2fp_lane
    import vcvt_pkg::*;
(
    input  logic [LANE_W-1:0] din,
    input  rmode_e            rm,
    output sp_t               dout,
    output logic              inexact
);
    logic [31:0] mag;
    logic [31:0] norm;
    logic [5:0]  lz;
    logic [7:0]  exp_raw;
    logic        guard, sticky, up;
    logic [30:0] sum;

    assign mag = din[31] ? (~din + 32'd1) : din;

    lzc #(.W(32)) u_lzc (.v(mag), .cnt(lz));

    always_comb begin
        norm    = mag << lz[4:0];
        guard   = norm[7];
        sticky  = |norm[6:0];
        exp_raw = 8'(EXP_TOP) - {2'b00, lz};
        up      = round_up(rm, din[31], norm[8], guard, sticky);
        sum     = {exp_raw, norm[30:8]} + 31'(up);
        if (mag == 32'd0) begin
            dout    = '0;
            inexact = 1'b0;
        end else begin
            dout    = {din[31], sum};
            inexact = guard | sticky;
        end
    end
endmodule

// File: rtl/vcvt_group.sv
module vcvt_group
    import vcvt_pkg::*;
#(
    parameter int VL    = 128,
    parameter int NREGS = 32,
    localparam int LANES = VL / LANE_W,
    localparam int AW    = $clog2(NREGS),
    localparam int GW    = AW - 1,
    localparam int MAXG  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode4,
    input  logic [GW-1:0] src_grp,
    input  logic [GW-1:0] dst_grp,
    input  logic [1:0]    rmode,
    output logic          busy,
    output logic          done,
    output logic          inexact,
    output logic [AW-1:0] rf_raddr,
    input  logic [VL-1:0] rf_rdata,
    output logic          rf_we,
    output logic [AW-1:0] rf_waddr,
    output logic [VL-1:0] rf_wdata
);
    state_e        state;
    logic [1:0]    step, last;
    logic [AW-1:0] src_base, dst_base;
    rmode_e        rm_q;
    logic          inexact_q, done_q;
    logic [VL-1:0] res_buf [MAXG];
    logic [VL-1:0] conv;
    logic [LANES-1:0] lane_inx;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sp_t lane_out;
        int2fp_lane u_cvt (
            .din     (rf_rdata[g*LANE_W +: LANE_W]),
            .rm      (rm_q),
            .dout    (lane_out),
            .inexact (lane_inx[g])
        );
        assign conv[g*LANE_W +: LANE_W] = lane_out;
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign inexact  = inexact_q;
    assign rf_raddr = src_base + AW'(step);
    assign rf_waddr = dst_base + AW'(step);
    assign rf_we    = (state == ST_WRITE);
    assign rf_wdata = res_buf[step];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step      <= '0;
            last      <= '0;
            src_base  <= '0;
            dst_base  <= '0;
            rm_q      <= RM_NEAREST;
            inexact_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        src_base  <= mode4 ? {src_grp[GW-2:0], 2'b00} : {src_grp, 1'b0};
                        dst_base  <= mode4 ? {dst_grp[GW-2:0], 2'b00} : {dst_grp, 1'b0};
                        last      <= mode4 ? 2'd3 : 2'd1;
                        rm_q      <= rmode_e'(rmode);
                        step      <= '0;
                        inexact_q <= 1'b0;
                        state     <= ST_READ;
                    end
                end
                ST_READ: begin
                    res_buf[step] <= conv;
                    inexact_q     <= inexact_q | (|lane_inx);
                    if (step == last) begin
                        step  <= '0;
                        state <= ST_WRITE;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                ST_WRITE: begin
                    if (step == last) begin
                        step   <= '0;
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vcvt_group_chk.sv
module vcvt_group_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          inexact,
    input logic          rf_we,
    input logic [AW-1:0] rf_waddr
);
    a_r8_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> busy);

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !rf_we));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_read_phase_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !rf_we);

    a_r7_write_after_read: assert property (@(posedge clk) disable iff (rst)
        $rose(rf_we) |-> $past(busy));

    a_r6_ascending_writes: assert property (@(posedge clk) disable iff (rst)
        (rf_we && $past(rf_we)) |-> (rf_waddr == AW'($past(rf_waddr) + AW'(1))));

    a_r5_flag_held_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(inexact));
endmodule

bind vcvt_group vcvt_group_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .inexact  (inexact),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr)
);

// File: tb/vcvt_group_test.sv
module vcvt_group_test;
    localparam int VL = 128;
    localparam int NR = 32;
    localparam int LN = VL / 32;

    logic          clk = 1'b0;
    logic          rst, start, mode4;
    logic [3:0]    src_grp, dst_grp;
    logic [1:0]    rmode;
    logic          busy, done, inexact, rf_we;
    logic [4:0]    rf_raddr, rf_waddr;
    logic [VL-1:0] rf_rdata, rf_wdata;
    logic [VL-1:0] rf [NR];

    always #4 clk = ~clk;

    vcvt_group #(.VL(VL), .NREGS(NR)) uut (
        .clk(clk), .rst(rst), .start(start), .mode4(mode4),
        .src_grp(src_grp), .dst_grp(dst_grp), .rmode(rmode),
        .busy(busy), .done(done), .inexact(inexact),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    assign rf_rdata = rf[rf_raddr];
    always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

    typedef struct {
        logic [4:0]    addr;
        logic [VL-1:0] data;
    } item_t;
    item_t sb_q[$];

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void ref_cvt(input logic [31:0] x, input logic [1:0] rm,
                                    output logic [31:0] f, output bit inx);
        longint v, m, q, r, half;
        int e, sh;
        bit s, up;
        v = longint'(signed'(x));
        s = (v < 0);
        m = s ? -v : v;
        inx = 0;
        f = '0;
        if (m == 0) return;
        e = 0;
        for (int i = 0; i < 32; i++) if (m[i]) e = i;
        if (e <= 23) begin
            q = m << (23 - e);
        end else begin
            sh   = e - 23;
            q    = m >> sh;
            r    = m - (q << sh);
            half = 64'sd1 << (sh - 1);
            inx  = (r != 0);
            case (rm)
                2'b00:   up = (r > half) || ((r == half) && q[0]);
                2'b01:   up = !s && inx;
                2'b10:   up = s && inx;
                default: up = 0;
            endcase
            q = q + longint'(up);
            if (q == (64'sd1 << 24)) begin
                q = q >> 1;
                e++;
            end
        end
        f = {s, 8'(e + 127), q[22:0]};
    endfunction

    // monitor: compares each write against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && rf_we) begin
            if (sb_q.size() == 0) begin
                chk(0, "R9 unexpected write", {27'd0, rf_waddr}, 32'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(rf_waddr == it.addr, "R6 write address", {27'd0, rf_waddr}, {27'd0, it.addr});
                for (int k = 0; k < LN; k++)
                    chk(rf_wdata[32*k +: 32] == it.data[32*k +: 32], "R1 R3 R7 lane data",
                        rf_wdata[32*k +: 32], it.data[32*k +: 32]);
            end
        end
    end

    task automatic run_op(input bit m4, input logic [3:0] sg, input logic [3:0] dg,
                          input logic [1:0] rm, input bit poke);
        int n, cyc;
        logic [4:0] sb, db;
        logic [VL-1:0] snap [4];
        logic [VL-1:0] res;
        logic [31:0] f;
        bit li, exp_inx;
        n  = m4 ? 4 : 2;
        sb = m4 ? {sg[2:0], 2'b00} : {sg, 1'b0};
        db = m4 ? {dg[2:0], 2'b00} : {dg, 1'b0};
        exp_inx = 0;
        for (int r = 0; r < n; r++) snap[r] = rf[5'(sb + r)];
        for (int r = 0; r < n; r++) begin
            for (int k = 0; k < LN; k++) begin
                ref_cvt(snap[r][32*k +: 32], rm, f, li);
                res[32*k +: 32] = f;
                exp_inx |= li;
            end
            sb_q.push_back('{addr: 5'(db + r), data: res});
        end
        @(negedge clk);
        start = 1; mode4 = m4; src_grp = sg; dst_grp = dg; rmode = rm;
        @(negedge clk);
        start = 0;
        cyc = 1;
        chk(busy == 1'b1, "R8 busy after start", {31'd0, busy}, 32'd1);
        if (poke) begin
            start = 1; mode4 = ~m4; src_grp = 4'd0; dst_grp = 4'd15; rmode = ~rm;
            @(negedge clk);
            start = 0;
            cyc++;
        end
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 2 * n + 1, "R8 cycles to done", cyc, 2 * n + 1);
        chk(busy == 1'b0, "R8 idle at done", {31'd0, busy}, 32'd0);
        chk(inexact == exp_inx, "R5 inexact flag", {31'd0, inexact}, {31'd0, exp_inx});
        chk(sb_q.size() == 0, "R9 all writes seen", sb_q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
    endtask

    function automatic logic [31:0] lane(input int reg_i, input int k);
        return rf[reg_i][32*k +: 32];
    endfunction

    function automatic logic [31:0] rnd_int();
        logic [31:0] v;
        v = $urandom >> ($urandom % 32);
        if ($urandom % 2) v = ~v + 32'd1;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++)
            for (int k = 0; k < LN; k++) rf[i][32*k +: 32] = $urandom;
        rst = 1; start = 0; mode4 = 0; src_grp = 0; dst_grp = 0; rmode = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R8 reset idle", {30'd0, busy, done}, 32'd0);
        chk(rf_we == 0, "R9 no write after reset", {31'd0, rf_we}, 32'd0);
        chk(inexact == 0, "R5 flag clear after reset", {31'd0, inexact}, 32'd0);

        rf[2] = {32'hFFFFFFFF, 32'd1, 32'h80000000, 32'd0};
        rf[3] = {32'hFEFFFFFF, 32'd16777219, 32'd16777217, 32'h7FFFFFFF};

        run_op(0, 4'd1, 4'd5, 2'b00, 0);
        chk(lane(10, 0) == 32'h00000000, "R2 zero", lane(10, 0), 32'h00000000);
        chk(lane(10, 1) == 32'hCF000000, "R2 most negative", lane(10, 1), 32'hCF000000);
        chk(lane(10, 2) == 32'h3F800000, "R1 one", lane(10, 2), 32'h3F800000);
        chk(lane(10, 3) == 32'hBF800000, "R1 minus one", lane(10, 3), 32'hBF800000);
        chk(lane(11, 0) == 32'h4F000000, "R4 carry nearest", lane(11, 0), 32'h4F000000);
        chk(lane(11, 1) == 32'h4B800000, "R3 tie even down", lane(11, 1), 32'h4B800000);
        chk(lane(11, 2) == 32'h4B800002, "R3 tie even up", lane(11, 2), 32'h4B800002);
        chk(lane(11, 3) == 32'hCB800000, "R3 negative tie", lane(11, 3), 32'hCB800000);

        run_op(0, 4'd1, 4'd6, 2'b11, 0);
        chk(lane(13, 0) == 32'h4EFFFFFF, "R4 toward zero no carry", lane(13, 0), 32'h4EFFFFFF);
        chk(lane(13, 3) == 32'hCB800000, "R3 toward zero", lane(13, 3), 32'hCB800000);

        run_op(0, 4'd1, 4'd7, 2'b01, 0);
        chk(lane(15, 1) == 32'h4B800001, "R3 toward +inf", lane(15, 1), 32'h4B800001);
        chk(lane(15, 3) == 32'hCB800000, "R3 toward +inf negative", lane(15, 3), 32'hCB800000);

        run_op(0, 4'd1, 4'd8, 2'b10, 0);
        chk(lane(17, 1) == 32'h4B800000, "R3 toward -inf", lane(17, 1), 32'h4B800000);
        chk(lane(17, 3) == 32'hCB800001, "R3 toward -inf negative", lane(17, 3), 32'hCB800001);

        for (int m = 0; m < 4; m++) begin
            for (int i = 8; i < 12; i++)
                for (int k = 0; k < LN; k++) rf[i][32*k +: 32] = rnd_int();
            run_op(1, 4'd2, 4'd5, 2'(m), 0);
        end

        // R7: in-place group, R9: start pulse while busy
        for (int i = 4; i < 8; i++)
            for (int k = 0; k < LN; k++) rf[i][32*k +: 32] = rnd_int();
        run_op(1, 4'd1, 4'd1, 2'b00, 1);

        // R6: upper field bit ignored in four-register mode
        run_op(1, 4'b1010, 4'b1111, 2'b01, 0);

        // R5: exact-only operation clears the flag
        rf[24] = {32'd7, 32'hFFFFFF00, 32'd16777215, 32'd42};
        rf[25] = {32'hFF000000, 32'd0, 32'd1024, 32'hFFFFFFFB};
        run_op(0, 4'd12, 4'd13, 2'b00, 0);
        chk(inexact == 1'b0, "R5 exact group", {31'd0, inexact}, 32'd0);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R9 no extra writes", sb_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule